// File: doc/BRIEF.md
# Cascadable Codec Clock Generator

This block produces the bit clock and frame sync for a serial codec port, all inside one system clock domain. In codec-slave mode the port does not drive its clock pins. It forwards the externally supplied bit clock and frame sync to the port's own logic. In codec-master mode it generates both signals itself, using two programmable dividers that count ticks of a selectable reference.

The reference is either a local master-audio-clock enable strobe or the bit clock of a designated master port. When the master port's bit clock is the reference, it is first synchronized into the system clock domain. It can be used at its own rate, where rising edges count as ticks, or at double rate, where both edges count. Several master-mode ports can therefore stay locked to one port that receives its clock from outside. The port acting as that cascade master must itself be in codec-slave mode.

Outputs are registered levels and single-cycle strobes; no clock is ever gated. A controller with states IDLE, LOW and HIGH sequences the bit clock. IDLE goes to LOW when generation is enabled. LOW goes to HIGH at the end of a half period, and that move is the rising edge. HIGH goes back to LOW at the end of a half period, and that move is the falling edge. Every state returns to IDLE as soon as generation is disabled.

Top module: `codec_clkgen`

## Requirements
- R1: While reset is asserted, every output is 0.
- R2: When gen_clk_en is 0, bclk_o and fsync_o are held at 0. port_bclk_o and port_fsync_o equal ext_bclk_in and ext_fsync_in as sampled at the previous clock edge.
- R3: When gen_clk_en goes from 1 to 0, bclk_o and fsync_o are 0 from the next clock edge onward.
- R4: With casc_sel = 0, each high half and each low half of bclk_o spans exactly bclk_div_val+1 cycles in which mclk_tick was 1.
- R5: With casc_sel = 1 and casc_dbl = 0, each half of bclk_o spans exactly bclk_div_val+1 rising edges of casc_bclk_in.
- R6: With casc_sel = 1 and casc_dbl = 1, each half of bclk_o spans exactly bclk_div_val+1 edges of casc_bclk_in, counting rising and falling edges alike.
- R7: A frame lasts frame_len_val+1 bit clocks. Bit 0 begins with the first rising edge of bclk_o after generation is enabled.
- R8: fsync_o is active high. It changes only together with a rising edge of bclk_o, and it is 1 during bits 0 through fs_width_val of each frame, which is fs_width_val+1 bit clocks.
- R9: bclk_rise_o and bclk_fall_o each pulse for one cycle in the cycle where bclk_o has just risen or fallen, and are 0 otherwise. frame_start_o pulses with the rising edge that starts bit 0.
- R10: New values of bclk_div_val, frame_len_val and fs_width_val take effect only at the falling edge that ends the last bit of a frame, or immediately while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_clk_en | input | 1 | 1 = codec master (generate), 0 = codec slave (pass through) |
| casc_sel | input | 1 | 1 = count the master port's bit clock instead of mclk_tick |
| casc_dbl | input | 1 | With casc_sel, count both edges of the master port's bit clock |
| mclk_tick | input | 1 | Local master audio clock enable, one tick per cycle high |
| casc_bclk_in | input | 1 | Master port's bit clock level, asynchronous |
| ext_bclk_in | input | 1 | External bit clock in codec-slave mode |
| ext_fsync_in | input | 1 | External frame sync in codec-slave mode |
| bclk_div_val | input | DIV_W | Half-period length in reference ticks, minus one |
| frame_len_val | input | FS_W | Frame length in bit clocks, minus one |
| fs_width_val | input | FS_W | Frame sync width in bit clocks, minus one |
| bclk_o | output | 1 | Generated bit clock level |
| fsync_o | output | 1 | Generated frame sync level |
| bclk_rise_o | output | 1 | Strobe on the bit clock rising edge |
| bclk_fall_o | output | 1 | Strobe on the bit clock falling edge |
| frame_start_o | output | 1 | Strobe on the rising edge that starts bit 0 |
| port_bclk_o | output | 1 | Bit clock the port uses (generated or forwarded) |
| port_fsync_o | output | 1 | Frame sync the port uses (generated or forwarded) |

## Verification
The bench builds the block with DIV_W = 4 and FS_W = 5. These small widths let it cover short frames and the full range of frame sync widths while keeping the bit clock only a few dozen cycles long. The divider is driven from 0, where every reference tick ends a half period, up to 4. The frame length runs from two bits to ten, with fsync widths from a single bit to all but the last bit. The same configurations run with a sparse random mclk_tick, with a slowly toggling asynchronous master bit clock at single and double rate, and with register rewrites in the middle of a frame.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } ccg_state_e;

endpackage

// File: rtl/ccg_ref_sel.sv
module ccg_ref_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic casc_sel,
    input  logic casc_dbl,
    input  logic mclk_tick,
    input  logic casc_bclk_in,
    output logic ref_tick
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;
    logic              synced;
    logic              synced_d;
    logic              casc_rise;
    logic              casc_fall;

    // synchronizer chain plus one stage of history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], casc_bclk_in};
        end
    end

    assign synced    = pipe_q[SYNC_STAGES-1];
    assign synced_d  = pipe_q[SYNC_STAGES];
    assign casc_rise = synced & ~synced_d;
    assign casc_fall = ~synced & synced_d;

    always_comb begin
        if (casc_sel) begin
            ref_tick = casc_rise | (casc_dbl & casc_fall);
        end else begin
            ref_tick = mclk_tick;
        end
    end

endmodule

// File: rtl/ccg_half_div.sv
module ccg_half_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [DIV_W-1:0] limit,
    output logic             half_end
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit);
    assign half_end = run & tick & at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= limit); // R4

endmodule

// File: rtl/ccg_frame_ctr.sv
module ccg_frame_ctr #(
    parameter int FS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            adv,
    input  logic [FS_W-1:0] limit,
    output logic [FS_W-1:0] bit_idx,
    output logic            last_bit
);
    assign last_bit = (bit_idx == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (!run) begin
            bit_idx <= '0;
        end else if (adv) begin
            bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
        end
    end

    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_idx <= limit); // R7

endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen
    import ccg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int FS_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gen_clk_en,
    input  logic            casc_sel,
    input  logic            casc_dbl,
    input  logic            mclk_tick,
    input  logic            casc_bclk_in,
    input  logic            ext_bclk_in,
    input  logic            ext_fsync_in,
    input  logic [DIV_W-1:0] bclk_div_val,
    input  logic [FS_W-1:0] frame_len_val,
    input  logic [FS_W-1:0] fs_width_val,
    output logic            bclk_o,
    output logic            fsync_o,
    output logic            bclk_rise_o,
    output logic            bclk_fall_o,
    output logic            frame_start_o,
    output logic            port_bclk_o,
    output logic            port_fsync_o
);
    ccg_state_e state_q;
    ccg_state_e state_nx;

    logic             ref_tick;
    logic             half_end;
    logic             running;
    logic             rise_ev;
    logic             fall_ev;
    logic             load_sh;
    logic             last_bit;
    logic [FS_W-1:0]  bit_idx;
    logic [DIV_W-1:0] div_sh;
    logic [FS_W-1:0]  len_sh;
    logic [FS_W-1:0]  wid_sh;
    logic             bclk_nx;
    logic             fsync_nx;

    ccg_ref_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref (
        .clk          (clk),
        .rst_n        (rst_n),
        .casc_sel     (casc_sel),
        .casc_dbl     (casc_dbl),
        .mclk_tick    (mclk_tick),
        .casc_bclk_in (casc_bclk_in),
        .ref_tick     (ref_tick)
    );

    assign running = (state_q != ST_IDLE) && gen_clk_en;

    ccg_half_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .tick     (ref_tick),
        .limit    (div_sh),
        .half_end (half_end)
    );

    assign rise_ev = running && (state_q == ST_LOW)  && half_end;
    assign fall_ev = running && (state_q == ST_HIGH) && half_end;

    ccg_frame_ctr #(
        .FS_W (FS_W)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .adv      (fall_ev),
        .limit    (len_sh),
        .bit_idx  (bit_idx),
        .last_bit (last_bit)
    );

    // divider settings are sampled while idle or at the end of a frame
    assign load_sh = (state_q == ST_IDLE) || (fall_ev && last_bit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_sh <= '0;
            len_sh <= '0;
            wid_sh <= '0;
        end else if (load_sh) begin
            div_sh <= bclk_div_val;
            len_sh <= frame_len_val;
            wid_sh <= fs_width_val;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (gen_clk_en) state_nx = ST_LOW;
            end
            ST_LOW: begin
                if (!gen_clk_en)   state_nx = ST_IDLE;
                else if (half_end) state_nx = ST_HIGH;
            end
            ST_HIGH: begin
                if (!gen_clk_en)   state_nx = ST_IDLE;
                else if (half_end) state_nx = ST_LOW;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    assign bclk_nx = (state_nx == ST_HIGH);

    always_comb begin
        if (state_nx == ST_IDLE) begin
            fsync_nx = 1'b0;
        end else if (rise_ev) begin
            fsync_nx = (bit_idx <= wid_sh);
        end else begin
            fsync_nx = fsync_o;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_o        <= 1'b0;
            fsync_o       <= 1'b0;
            bclk_rise_o   <= 1'b0;
            bclk_fall_o   <= 1'b0;
            frame_start_o <= 1'b0;
            port_bclk_o   <= 1'b0;
            port_fsync_o  <= 1'b0;
        end else begin
            bclk_o        <= bclk_nx;
            fsync_o       <= fsync_nx;
            bclk_rise_o   <= rise_ev;
            bclk_fall_o   <= fall_ev;
            frame_start_o <= rise_ev && (bit_idx == '0);
            port_bclk_o   <= gen_clk_en ? bclk_nx  : ext_bclk_in;
            port_fsync_o  <= gen_clk_en ? fsync_nx : ext_fsync_in;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !gen_clk_en |=> (!bclk_o && !fsync_o)); // R3
    AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) !gen_clk_en |=> (port_bclk_o == $past(ext_bclk_in))); // R2
    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n) bclk_rise_o |-> (bclk_o && !$past(bclk_o))); // R9
    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n) bclk_fall_o |-> (!bclk_o && $past(bclk_o))); // R9
    AST_FS_AT_START: assert property (@(posedge clk) disable iff (!rst_n) frame_start_o |-> fsync_o); // R8
    AST_FS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) (gen_clk_en && !bclk_rise_o) |-> (fsync_o == $past(fsync_o) || !fsync_o)); // R8

endmodule

// File: tb/sim_codec_clkgen.sv
module sim_codec_clkgen;
    localparam int DIV_W = 4;
    localparam int FS_W  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gen_clk_en = 1'b0;
    logic casc_sel = 1'b0;
    logic casc_dbl = 1'b0;
    logic mclk_tick = 1'b0;
    logic casc_bclk_in = 1'b0;
    logic ext_bclk_in = 1'b0;
    logic ext_fsync_in = 1'b0;
    logic [DIV_W-1:0] bclk_div_val = '0;
    logic [FS_W-1:0]  frame_len_val = 5'd1;
    logic [FS_W-1:0]  fs_width_val = '0;
    logic bclk_o, fsync_o, bclk_rise_o, bclk_fall_o, frame_start_o, port_bclk_o, port_fsync_o;

    always #2.5 clk = ~clk;

    codec_clkgen #(.DIV_W(DIV_W), .FS_W(FS_W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .gen_clk_en(gen_clk_en), .casc_sel(casc_sel),
        .casc_dbl(casc_dbl), .mclk_tick(mclk_tick), .casc_bclk_in(casc_bclk_in),
        .ext_bclk_in(ext_bclk_in), .ext_fsync_in(ext_fsync_in),
        .bclk_div_val(bclk_div_val), .frame_len_val(frame_len_val), .fs_width_val(fs_width_val),
        .bclk_o(bclk_o), .fsync_o(fsync_o), .bclk_rise_o(bclk_rise_o), .bclk_fall_o(bclk_fall_o),
        .frame_start_o(frame_start_o), .port_bclk_o(port_bclk_o), .port_fsync_o(port_fsync_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int density = 100;
    bit wd_fail = 0;

    // monitor state
    int  tick_cnt = 0;
    int  tick_prev = 0;
    int  bitpos = 0;
    int  n_sh = 0, p_sh = 0, w_sh = 0;
    bit  skip_half = 1;
    bit  b_prev = 0;
    bit  gen_prev = 0;
    bit  ext_b_prev = 0, ext_f_prev = 0;
    int  casc_timer = 3;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string half_req(input bit cs, input bit dbl);
        if (!cs) return "R4";
        return dbl ? "R6" : "R5";
    endfunction

    function automatic bit fs_expect(input int pos, input int wid);
        return pos <= wid;
    endfunction

    always @(negedge clk) begin
        bit edge_now;
        if (!rst_n) begin
            chk({bclk_o, fsync_o, bclk_rise_o, bclk_fall_o, frame_start_o, port_bclk_o, port_fsync_o} == 7'd0,
                "R1", {bclk_o, fsync_o, bclk_rise_o, bclk_fall_o, frame_start_o, port_bclk_o, port_fsync_o}, 0);
            gen_prev = 0;
            tick_prev = 0;
        end else begin
            tick_cnt += tick_prev;
            if (gen_clk_en && !gen_prev) begin
                n_sh = bclk_div_val; p_sh = frame_len_val; w_sh = fs_width_val;
                bitpos = p_sh; skip_half = 1; tick_cnt = 0; b_prev = 0;
            end
            if (!gen_clk_en) begin
                chk(!bclk_o && !fsync_o, gen_prev ? "R3" : "R2", {bclk_o, fsync_o}, 0);
                chk(port_bclk_o == ext_b_prev && port_fsync_o == ext_f_prev, "R2",
                    {port_bclk_o, port_fsync_o}, {ext_b_prev, ext_f_prev});
            end else if (bclk_o != b_prev) begin
                if (bclk_o) begin
                    if (bitpos == p_sh) begin
                        bitpos = 0;
                        p_sh = frame_len_val; w_sh = fs_width_val; n_sh = bclk_div_val; // R10
                    end else begin
                        bitpos++;
                    end
                    chk(fsync_o == fs_expect(bitpos, w_sh), "R8", fsync_o, fs_expect(bitpos, w_sh));
                    chk(frame_start_o == (bitpos == 0), "R7", frame_start_o, bitpos == 0);
                    chk(bclk_rise_o && !bclk_fall_o, "R9", {bclk_rise_o, bclk_fall_o}, 2);
                end else begin
                    chk(bclk_fall_o && !bclk_rise_o, "R9", {bclk_rise_o, bclk_fall_o}, 1);
                    chk(fsync_o == fs_expect(bitpos, w_sh), "R8", fsync_o, fs_expect(bitpos, w_sh));
                end
                if (!skip_half)
                    chk(tick_cnt == n_sh + 1, half_req(casc_sel, casc_dbl), tick_cnt, n_sh + 1);
                skip_half = 0;
                tick_cnt = 0;
            end else begin
                chk(!bclk_rise_o && !bclk_fall_o && !frame_start_o, "R9",
                    {bclk_rise_o, bclk_fall_o, frame_start_o}, 0);
            end
            if (gen_clk_en) b_prev = bclk_o;
            gen_prev = gen_clk_en;
        end
        // drive stimulus for the next rising edge
        ext_bclk_in  = $urandom % 2;
        ext_fsync_in = $urandom % 2;
        ext_b_prev = ext_bclk_in;
        ext_f_prev = ext_fsync_in;
        mclk_tick = ($urandom % 100) < density;
        edge_now = 0;
        if (casc_timer == 0) begin
            casc_bclk_in = ~casc_bclk_in;
            casc_timer = 6 + ($urandom % 5);
            edge_now = 1;
        end else begin
            casc_timer--;
        end
        if (casc_sel) tick_prev = (edge_now && (casc_dbl || casc_bclk_in)) ? 1 : 0;
        else          tick_prev = mclk_tick ? 1 : 0;
    end

    task automatic run_cfg(input bit cs, input bit dbl, input int n, input int p, input int w,
                           input int dens, input int frames, input bit rewrite);
        @(negedge clk); #1;
        gen_clk_en = 0;
        repeat (3) @(negedge clk);
        #1;
        casc_sel = cs; casc_dbl = dbl; density = dens;
        bclk_div_val = n[DIV_W-1:0]; frame_len_val = p[FS_W-1:0]; fs_width_val = w[FS_W-1:0];
        @(negedge clk); #1;
        gen_clk_en = 1;
        repeat (frames) @(posedge frame_start_o);
        if (rewrite) begin
            @(negedge clk); #1;
            bclk_div_val  = DIV_W'(($urandom % 5));
            frame_len_val = FS_W'(1 + ($urandom % 9));
            fs_width_val  = FS_W'($urandom % (32'(frame_len_val)));
            repeat (3) @(posedge frame_start_o);
        end
        repeat ($urandom % 40) @(negedge clk);
    endtask

    initial begin
        int p;
        void'($urandom(32'd1234));
        fork
            begin
                repeat (4) @(negedge clk);
                #1 rst_n = 1;
                repeat (20) @(negedge clk);          // slave pass-through, R2
                run_cfg(0, 0, 0, 1, 0, 100, 3, 0);   // fastest divider, 2-bit frame
                run_cfg(0, 0, 3, 9, 8, 100, 2, 0);   // fsync all but last bit
                run_cfg(0, 0, 2, 4, 1, 40, 2, 1);    // sparse ticks, mid-frame rewrite R10
                run_cfg(1, 0, 1, 3, 0, 100, 2, 0);   // cascade, normal rate
                run_cfg(1, 1, 2, 5, 2, 100, 2, 1);   // cascade, double rate, rewrite
                for (int i = 0; i < 10; i++) begin
                    p = 1 + ($urandom % 9);
                    run_cfg($urandom % 2, $urandom % 2, $urandom % 5, p, $urandom % p,
                            30 + ($urandom % 71), 2, $urandom % 2);
                end
                @(negedge clk); #1 gen_clk_en = 0;
                repeat (20) @(negedge clk);
            end
            begin
                repeat (190000) @(posedge clk);
                wd_fail = 1;
            end
        join_any
        if (wd_fail) $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + wd_fail, n_fail + wd_fail);
        $finish;
    end

endmodule